// File: doc/BRIEF.md
# PWM Prescaler Clock-Enable Generator

This block gives a group of PWM channels a common set of time bases. A free-running binary counter on the master clock produces eleven enable strobes, at the master rate divided by 1, 2, 4 and so on up to 1024. Each strobe lasts one master-clock cycle. None of them is a derived clock, so every consumer stays in the single master clock domain.

Two independent linear dividers, A and B, stretch these further. Each picks one of the eleven strobes with a 4-bit select and counts its pulses against an 8-bit divide value. It emits its own one-cycle strobe on every Nth selected pulse. A divide value of zero parks that divider with its output low. A global enable stands in for gating the master clock to the controller.

Top module: `pwm_clkgen`

## Requirements
- R1: While `rst_n` is low, `tick[10:1]`, `tick_a` and `tick_b` are low, and the prescale count and both divider counts are held at zero.
- R2: With `en` high, count enabled cycles from 0 starting at the first enabled edge after reset or after `en` was low. `tick[k]` for k from 1 to 10 is high exactly in cycles whose index i satisfies i mod 2^k = 2^k-1, so it is a one-cycle pulse once every 2^k cycles.
- R3: `tick[0]` equals `en` at all times, so it is constantly high while the generator is enabled.
- R4: While `en` is low, `tick[10:1]`, `tick_a` and `tick_b` are low, and the prescale and divider counts return to zero.
- R5: A select value s from 0 to 10 makes the divider count pulses of `tick[s]`. Select values 11 to 15 select no source, and that divider's output stays low.
- R6: A divide value of 0 keeps that divider's output permanently low.
- R7: A divide value N from 1 to 255 makes the divider output pulse in the same cycle as every Nth pulse of its selected strobe. The interval between output pulses is N times the strobe interval.
- R8: In any cycle where a divide input differs from its value in the previous cycle, that divider gives no output pulse and its count restarts from zero. Its next pulse falls on the Nth selected strobe pulse after that cycle.
- R9: Dividers A and B are fully independent. Settings of one never change the output of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; low models the master clock being gated off |
| sel_a | input | 4 | Strobe select for divider A (0..10 valid, 11..15 off) |
| div_a | input | 8 | Divide value for divider A (0 = off) |
| sel_b | input | 4 | Strobe select for divider B (0..10 valid, 11..15 off) |
| div_b | input | 8 | Divide value for divider B (0 = off) |
| tick | output | 11 | Prescaled strobes; bit k pulses at master/2^k |
| tick_a | output | 1 | Divider A strobe |
| tick_b | output | 1 | Divider B strobe |

## Verification
The bench runs every prescale tap for over a full 1024-cycle wrap. A counter that wrapped early, or was off by one in its phase, would move `tick[10]` or shift every tap. It drops and raises `en` mid-count, which catches a counter that pauses instead of clearing and so resumes with a skewed phase. It walks each divider through all sixteen select codes, where a decoder that folded codes 11..15 onto a real tap would produce pulses. It changes a divide value mid-count and measures the gap to the next output, which exposes a divider that keeps its stale count or pulses in the change cycle. It also runs the extremes of 1 and 255 and runs A and B with different settings side by side to expose crosstalk.

// File: rtl/pwm_clkgen_pkg.sv
`timescale 1ns/1ps
package pwm_clkgen_pkg;
    // Default geometry shared by the generator and its sub-blocks
    localparam int unsigned TAPS_DEF  = 11; // divide by 2^0 .. 2^10
    localparam int unsigned SEL_W_DEF = 4;
    localparam int unsigned DIV_W_DEF = 8;

    // Divider register contents
    typedef struct packed {
        logic [DIV_W_DEF-1:0] cnt;
        logic [DIV_W_DEF-1:0] prev;
    } div_state_t;
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
    parameter int unsigned NUM_TAPS = pwm_clkgen_pkg::TAPS_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    output logic [NUM_TAPS-1:0] tick
);
    localparam int unsigned CNT_W = NUM_TAPS - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Tap 0 is the undivided rate; tap k fires when the low k bits are all ones
    assign tick[0] = en;
    for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
        assign tick[k] = en && (&st_q.cnt[k-1:0]);

        // R2: a slower tap only fires together with the next faster one
        assert_tap_nested_R2: assert property (@(posedge clk) disable iff (!rst_n)
            tick[k] |-> tick[k-1]);
        // R2: divided taps are single-cycle strobes
        assert_tap_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
            tick[k] |=> !tick[k]);
    end

    // R4: dropping the enable clears the prescale count at the next edge
    assert_idle_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == '0));

    // R3: undivided strobe tracks the enable
    always_comb begin
        assert_tick0_en_R3: assert (tick[0] == en);
    end
endmodule

// File: rtl/pwm_lin_div.sv
`timescale 1ns/1ps
module pwm_lin_div #(
    parameter int unsigned NUM_TAPS = pwm_clkgen_pkg::TAPS_DEF,
    parameter int unsigned SEL_W    = pwm_clkgen_pkg::SEL_W_DEF,
    parameter int unsigned DIV_W    = pwm_clkgen_pkg::DIV_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic [SEL_W-1:0]    sel,
    input  logic [DIV_W-1:0]    div,
    output logic                tick_out
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] prev;
    } ld_state_t;

    ld_state_t  st_d, st_q;
    logic       src_tick;
    logic       reload;
    logic       div_off;
    logic       at_end;

    // Source decode: codes beyond the tap range select nothing
    always_comb begin
        src_tick = 1'b0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            if (sel == SEL_W'(i)) begin
                src_tick = taps[i];
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        reload    = (div != st_q.prev);
        div_off   = (div == '0);
        at_end    = (st_q.cnt == (div - DIV_W'(1)));
        st_d.prev = div;
        if (!en || reload || div_off) begin
            st_d.cnt = '0;
        end else if (src_tick) begin
            st_d.cnt = at_end ? '0 : st_q.cnt + 1'b1;
        end
        tick_out = en && src_tick && !reload && !div_off && at_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: output only ever coincides with the selected strobe
    assert_out_on_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> src_tick);
    // R5: unmapped select codes keep the output low
    assert_bad_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel >= SEL_W'(NUM_TAPS)) |-> !tick_out);
    // R6: zero divide value parks the divider
    assert_zero_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |-> !tick_out);
    // R8: no pulse in a cycle where the divide value just changed
    assert_change_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (div != $past(div)) |-> !tick_out);
    // R8: a change restarts the count
    assert_change_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (div != $past(div)) |=> (st_q.cnt == '0));
endmodule

// File: rtl/pwm_clkgen.sv
`timescale 1ns/1ps
module pwm_clkgen #(
    parameter int unsigned NUM_TAPS = pwm_clkgen_pkg::TAPS_DEF,
    parameter int unsigned SEL_W    = pwm_clkgen_pkg::SEL_W_DEF,
    parameter int unsigned DIV_W    = pwm_clkgen_pkg::DIV_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [SEL_W-1:0]    sel_a,
    input  logic [DIV_W-1:0]    div_a,
    input  logic [SEL_W-1:0]    sel_b,
    input  logic [DIV_W-1:0]    div_b,
    output logic [NUM_TAPS-1:0] tick,
    output logic                tick_a,
    output logic                tick_b
);
    localparam int unsigned NUM_DIV = 2;

    logic [NUM_DIV-1:0][SEL_W-1:0] sel_v;
    logic [NUM_DIV-1:0][DIV_W-1:0] div_v;
    logic [NUM_DIV-1:0]            out_v;

    assign sel_v[0] = sel_a;
    assign sel_v[1] = sel_b;
    assign div_v[0] = div_a;
    assign div_v[1] = div_b;
    assign tick_a   = out_v[0];
    assign tick_b   = out_v[1];

    pwm_prescaler #(
        .NUM_TAPS (NUM_TAPS)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick  (tick)
    );

    for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
        pwm_lin_div #(
            .NUM_TAPS (NUM_TAPS),
            .SEL_W    (SEL_W),
            .DIV_W    (DIV_W)
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en),
            .taps     (tick),
            .sel      (sel_v[d]),
            .div      (div_v[d]),
            .tick_out (out_v[d])
        );
    end

    // R4: nothing divided fires while disabled
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (tick[NUM_TAPS-1:1] == '0) && !tick_a && !tick_b);
endmodule

// File: tb/pwm_clkgen_tb.sv
`timescale 1ns/1ps
module pwm_clkgen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [3:0]  sel_a = '0, sel_b = '0;
    logic [7:0]  div_a = '0, div_b = '0;
    logic [10:0] tick;
    logic        tick_a, tick_b;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pwm_clkgen u_dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .sel_a(sel_a), .div_a(div_a), .sel_b(sel_b), .div_b(div_b),
        .tick(tick), .tick_a(tick_a), .tick_b(tick_b)
    );

    // Reference state built from the requirements
    int m_cnt = 0;
    int m_da = 0, m_db = 0;
    int m_pa = 0, m_pb = 0;

    function automatic bit exp_tap(int k);
        if (k == 0) return en;
        if (k > 10) return 1'b0;
        return en && ((m_cnt % (1 << k)) == ((1 << k) - 1));
    endfunction

    function automatic bit exp_div(int sel, int dv, int prev, int c);
        return en && exp_tap(sel) && dv != 0 && dv == prev && c == dv - 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_da <= 0; m_db <= 0; m_pa <= 0; m_pb <= 0;
        end else begin
            m_cnt <= en ? (m_cnt + 1) % 1024 : 0;
            m_pa  <= div_a;
            m_pb  <= div_b;
            if (!en || int'(div_a) != m_pa || div_a == 0) m_da <= 0;
            else if (exp_tap(sel_a)) m_da <= (m_da == div_a - 1) ? 0 : m_da + 1;
            if (!en || int'(div_b) != m_pb || div_b == 0) m_db <= 0;
            else if (exp_tap(sel_b)) m_db <= (m_db == div_b - 1) ? 0 : m_db + 1;
        end
    end

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        logic [10:0] et;
        bit ea, eb;
        for (int k = 0; k < 11; k++) et[k] = exp_tap(k);
        ea = exp_div(sel_a, div_a, m_pa, m_da);
        eb = exp_div(sel_b, div_b, m_pb, m_db);
        check(tick === et, tag, "tick", tick, et);
        check(tick_a === ea, tag, "tick_a", tick_a, ea);
        check(tick_b === eb, tag, "tick_b", tick_b, eb);
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare(tag);
        end
    endtask

    // R1: reset state, with enable and dividers driven
    task automatic t_reset();
        rst_n = 1'b0; en = 1'b1; sel_a = 4'd0; div_a = 8'd1; sel_b = 4'd1; div_b = 8'd2;
        run(4, "R1");
        check(tick[10:1] == 0, "R1", "taps in reset", tick[10:1], 0);
        @(negedge clk);
        rst_n = 1'b1; en = 1'b0; div_a = 0; div_b = 0;
        run(2, "R1");
    endtask

    // R2/R3: full wrap of every tap
    task automatic t_prescale();
        en = 1'b1;
        run(2100, "R2");
        check(tick[0] == 1'b1, "R3", "tick0 while enabled", tick[0], 1);
    endtask

    // R4: disable mid-count, then restart from zero
    task automatic t_disable();
        sel_a = 4'd0; div_a = 8'd3;
        run(37, "R4");
        en = 1'b0;
        run(20, "R4");
        check(tick[0] == 1'b0, "R3", "tick0 when disabled", tick[0], 0);
        en = 1'b1;
        run(70, "R4");
    endtask

    // R5: every select code, including the unmapped ones
    task automatic t_select();
        int seen;
        div_a = 8'd1; div_b = 8'd0;
        for (int s = 0; s < 16; s++) begin
            sel_a = 4'(s);
            seen = 0;
            for (int i = 0; i < 1100; i++) begin
                @(negedge clk);
                compare("R5");
                if (tick_a) seen++;
            end
            if (s > 10) check(seen == 0, "R5", "pulses on unmapped code", seen, 0);
            else        check(seen > 0, "R5", "pulses on valid code", seen, 1);
        end
    endtask

    // R6/R7: zero, small, extreme divide values and a measured period
    task automatic t_divide();
        int last, gap, hits;
        sel_a = 4'd3; div_a = 8'd0;
        run(100, "R6");
        div_a = 8'd255;
        run(2100, "R7");
        sel_a = 4'd2; div_a = 8'd5;
        last = -1; gap = 0; hits = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            compare("R7");
            if (tick_a) begin
                if (last >= 0) gap = i - last;
                last = i; hits++;
            end
        end
        check(hits >= 2 && gap == 20, "R7", "period 4x5", gap, 20);
    endtask

    // R8: change divide value mid-count
    task automatic t_change();
        sel_a = 4'd0; div_a = 8'd10;
        run(15, "R8");
        div_a = 8'd4;
        #1;
        check(tick_a == 1'b0, "R8", "pulse in change cycle", tick_a, 0);
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            compare("R8");
            check(tick_a == (i == 4), "R8", "restart phase", tick_a, (i == 4));
        end
        run(20, "R8");
    endtask

    // R9: A and B with different settings side by side
    task automatic t_indep();
        int ca, cb;
        sel_a = 4'd1; div_a = 8'd3; sel_b = 4'd4; div_b = 8'd2;
        run(4, "R9");
        ca = 0; cb = 0;
        for (int i = 0; i < 192; i++) begin
            @(negedge clk);
            compare("R9");
            if (tick_a) ca++;
            if (tick_b) cb++;
        end
        check(ca == 32, "R9", "A count", ca, 32);
        check(cb == 6, "R9", "B count", cb, 6);
        div_b = 8'd0;
        run(60, "R9");
    endtask

    initial begin
        t_reset();
        t_prescale();
        t_disable();
        t_select();
        t_divide();
        t_change();
        t_indep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule